// File: doc/BRIEF.md
# Asynchronous Character Receiver with Block Termination

The block receives characters from an asynchronous serial line and writes them out through a FIFO write port. It oversamples the line at sixteen times the bit rate from a simple clock divider. Each character has a start bit, five to eight data bits sent LSB first, an optional even or odd parity bit and one or two stop bits. A falling edge on a line that was idle and high starts a character. The start bit is checked again at its midpoint, and each later bit is sampled at its own midpoint.

Received characters are grouped into blocks. A block is closed by a programmable termination character or by a software force-end pulse. Either one raises the termination event, latches the block length and clears the running byte counter. When the time-out is armed, an idle gap of four character frame lengths after the last character raises a time-out event once. Parity and framing errors are reported as one-cycle event pulses. When status storage is enabled, they are also written as a status byte right after the character they belong to.

The receive state machine `rx_frame` has the states RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP, with these transitions:

- RX_IDLE→RX_START on a high-to-low line edge.
- RX_START→RX_IDLE when the line is high again at mid-start (a glitch).
- RX_START→RX_DATA when the line is still low at mid-start.
- RX_DATA→RX_PAR or RX_DATA→RX_STOP after the last data bit, depending on whether parity is enabled.
- RX_PAR→RX_STOP after the parity sample.
- RX_STOP→RX_IDLE after the final stop sample, which also emits the character.

The time-out machine in `blk_track` has the states TM_IDLE and TM_RUN:

- TM_IDLE→TM_RUN on a character while the time-out is enabled.
- TM_RUN→TM_RUN on a new character, which restarts the count.
- TM_RUN→TM_IDLE on expiry or when the time-out is disabled.

Top module: `async_blk_rx`

## Requirements
- R1: After reset, every event output and `wr_valid` is 0, and both `byte_cnt` and `blk_len` are 0.
- R2: Each received character is written once with `wr_valid`=1 and `wr_stat`=0. Its data bits are taken LSB first, and the number of data bits is 5 plus `len_sel` (00=5, 11=8). Unused upper bits of `wr_data` are 0.
- R3: A low pulse on the line shorter than half a bit time produces no write and leaves `byte_cnt` unchanged.
- R4: When `par_en`=1, a parity mismatch pulses `ev_perr` with the character's data write. Even parity is used when `par_odd`=0 and odd parity when `par_odd`=1. A character with correct parity gives no pulse.
- R5: A 0 sampled in any stop-bit position, including the second one when `two_stop`=1, pulses `ev_ferr` with the data write.
- R6: When `stat_en`=1, the cycle after each data write carries a status write with `wr_stat`=1 and `wr_data`={6'b0, framing error, parity error}, that is, bit 0 is the parity error and bit 1 the framing error.
- R7: When `term_en`=1, a character equal to `term_char` pulses `ev_term`. It sets `blk_len` to the number of characters in the block including the terminator, and it clears `byte_cnt` to 0.
- R8: A one-cycle `force_end` pulse raises `ev_term`, sets `blk_len` to the characters received so far in the block and clears `byte_cnt`.
- R9: When `tout_en`=1, `ev_tout` pulses once, about 4×CFL×16 clock ticks after the last character. CFL = 1 + data bits + parity bit + stop bits. It does not pulse again until another character arrives, and it never pulses while `tout_en`=0.
- R10: `byte_cnt` goes up by one with every character written, until the block ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 16 | The oversample tick fires every baud_div+1 clocks |
| rx | input | 1 | Serial line, idle high |
| len_sel | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | Two stop bits |
| stat_en | input | 1 | Append a status byte after each character |
| term_en | input | 1 | Enable termination-character compare |
| term_char | input | 8 | Termination character |
| force_end | input | 1 | Pulse: close the current block |
| tout_en | input | 1 | Enable idle time-out |
| wr_valid | output | 1 | FIFO write strobe |
| wr_data | output | 8 | FIFO write data |
| wr_stat | output | 1 | The current write is a status byte |
| ev_term | output | 1 | Block-termination event pulse |
| ev_tout | output | 1 | Time-out event pulse |
| ev_perr | output | 1 | Parity-error event pulse |
| ev_ferr | output | 1 | Framing-error event pulse |
| byte_cnt | output | 8 | Characters in the current block |
| blk_len | output | 8 | Length of the last closed block |

## Verification
A receive state machine stuck or misaligned in its bit phase shows up within one character frame. The result is a corrupted or shifted byte on `wr_data`, a missing write, or a spurious framing error. A wrong block counter is visible at the very next write through `byte_cnt`, and at the next termination through `blk_len`. A time-out counter with a wrong limit or a lost armed state moves or duplicates `ev_tout` against a window of a few dozen clocks around four frame lengths.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_t;

    typedef enum logic {
        TM_IDLE,
        TM_RUN
    } tm_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_char_t;
endpackage

// File: rtl/baud_tick.sv
module baud_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import async_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_in,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    output logic       ch_valid,
    output rx_char_t   ch
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_t  state, state_nx;
    logic [CW-1:0] ph;
    logic [2:0] bit_idx;
    logic [7:0] sh;
    logic       pbit, ferr, stop2, seen_hi;
    logic [7:0] dat;
    logic       samp, last_bit, last_stop;

    assign samp      = tick && (ph == LAST);
    assign last_bit  = (bit_idx == (3'd4 + {1'b0, len_sel}));
    assign last_stop = !two_stop || stop2;
    assign dat       = sh >> (2'd3 - len_sel);

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (tick && !rx_in && seen_hi) state_nx = RX_START;
            RX_START: if (tick && ph == MID) state_nx = rx_in ? RX_IDLE : RX_DATA;
            RX_DATA:  if (samp && last_bit) state_nx = par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (samp) state_nx = RX_STOP;
            RX_STOP:  if (samp && last_stop) state_nx = RX_IDLE;
            default:  state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0; bit_idx <= '0; sh <= '0; pbit <= 1'b0;
            ferr <= 1'b0; stop2 <= 1'b0; seen_hi <= 1'b0;
            ch_valid <= 1'b0; ch <= '0;
        end else begin
            ch_valid <= 1'b0;
            if (tick) begin
                ph <= ph + 1'b1;
                unique case (state)
                    RX_IDLE: begin
                        ph <= '0; bit_idx <= '0; stop2 <= 1'b0; ferr <= 1'b0;
                        seen_hi <= rx_in;
                    end
                    RX_START: begin
                        seen_hi <= 1'b0;
                        if (ph == MID) ph <= '0;
                    end
                    RX_DATA: if (ph == LAST) begin
                        ph <= '0;
                        sh <= {rx_in, sh[7:1]};
                        bit_idx <= bit_idx + 1'b1;
                    end
                    RX_PAR: if (ph == LAST) begin
                        ph <= '0;
                        pbit <= rx_in;
                    end
                    RX_STOP: if (ph == LAST) begin
                        ph <= '0;
                        stop2 <= 1'b1;
                        if (!rx_in) ferr <= 1'b1;
                        if (last_stop) begin
                            ch_valid <= 1'b1;
                            ch.data  <= dat;
                            ch.ferr  <= ferr | !rx_in;
                            ch.perr  <= par_en & (^dat ^ pbit ^ par_odd);
                        end
                    end
                    default: ph <= '0;
                endcase
            end
        end
    end

    // R2
    valid_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> $past(state) == RX_STOP);
    // R4
    perr_needs_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && ch.perr) |-> $past(par_en));
endmodule

// File: rtl/blk_track.sv
module blk_track
    import async_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int CNT_W = 8,
    parameter int TO_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ch_valid,
    input  rx_char_t         ch,
    input  logic [1:0]       len_sel,
    input  logic             par_en,
    input  logic             two_stop,
    input  logic             stat_en,
    input  logic             term_en,
    input  logic [7:0]       term_char,
    input  logic             force_end,
    input  logic             tout_en,
    output logic             wr_valid,
    output logic [7:0]       wr_data,
    output logic             wr_stat,
    output logic             ev_term,
    output logic             ev_tout,
    output logic             ev_perr,
    output logic             ev_ferr,
    output logic [CNT_W-1:0] byte_cnt,
    output logic [CNT_W-1:0] blk_len
);
    localparam int SH = $clog2(OVS) + 2;

    tm_state_t tm_state, tm_nx;
    logic [TO_W-1:0] tcnt, cfl, limit;
    logic stat_pend, st_perr, st_ferr, hit, end_now, expire;

    assign cfl     = TO_W'(7) + TO_W'(len_sel) + TO_W'(par_en) + TO_W'(two_stop);
    assign limit   = cfl << SH;
    assign hit     = ch_valid && term_en && (ch.data == term_char);
    assign end_now = hit || force_end;
    assign expire  = (tm_state == TM_RUN) && !ch_valid && tout_en && tick
                     && (tcnt == limit - 1'b1);

    always_comb begin
        tm_nx = tm_state;
        unique case (tm_state)
            TM_IDLE: if (ch_valid && tout_en) tm_nx = TM_RUN;
            TM_RUN:  if (ch_valid) tm_nx = TM_RUN;
                     else if (!tout_en || expire) tm_nx = TM_IDLE;
            default: tm_nx = TM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_state <= TM_IDLE;
        else        tm_state <= tm_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid <= 1'b0; wr_data <= '0; wr_stat <= 1'b0;
            ev_term <= 1'b0; ev_tout <= 1'b0; ev_perr <= 1'b0; ev_ferr <= 1'b0;
            byte_cnt <= '0; blk_len <= '0; tcnt <= '0;
            stat_pend <= 1'b0; st_perr <= 1'b0; st_ferr <= 1'b0;
        end else begin
            wr_valid <= 1'b0; wr_stat <= 1'b0;
            ev_term <= 1'b0; ev_perr <= 1'b0; ev_ferr <= 1'b0;
            ev_tout <= expire;
            if (stat_pend) begin
                wr_valid  <= 1'b1;
                wr_stat   <= 1'b1;
                wr_data   <= {6'b0, st_ferr, st_perr};
                stat_pend <= 1'b0;
            end
            if (ch_valid) begin
                wr_valid  <= 1'b1;
                wr_data   <= ch.data;
                ev_perr   <= ch.perr;
                ev_ferr   <= ch.ferr;
                stat_pend <= stat_en;
                st_perr   <= ch.perr;
                st_ferr   <= ch.ferr;
            end
            if (end_now) begin
                ev_term  <= 1'b1;
                blk_len  <= byte_cnt + {{(CNT_W-1){1'b0}}, ch_valid};
                byte_cnt <= '0;
            end else if (ch_valid) begin
                byte_cnt <= byte_cnt + 1'b1;
            end
            if (ch_valid)                         tcnt <= '0;
            else if (tm_state == TM_RUN && tick)  tcnt <= tcnt + 1'b1;
        end
    end

    // R6
    stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_stat && $past(stat_en)) |=> (wr_valid && wr_stat));
    // R7
    term_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_term |-> byte_cnt == '0);
    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_stat && !ev_term) |-> byte_cnt == $past(byte_cnt) + 1'b1);
    // R9
    tout_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tout |=> !ev_tout);
endmodule

// File: rtl/async_blk_rx.sv
module async_blk_rx
    import async_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DIV_W = 16,
    parameter int CNT_W = 8,
    parameter int TO_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             rx,
    input  logic [1:0]       len_sel,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             two_stop,
    input  logic             stat_en,
    input  logic             term_en,
    input  logic [7:0]       term_char,
    input  logic             force_end,
    input  logic             tout_en,
    output logic             wr_valid,
    output logic [7:0]       wr_data,
    output logic             wr_stat,
    output logic             ev_term,
    output logic             ev_tout,
    output logic             ev_perr,
    output logic             ev_ferr,
    output logic [CNT_W-1:0] byte_cnt,
    output logic [CNT_W-1:0] blk_len
);
    logic [1:0] rx_sync;
    logic       tick, ch_valid;
    rx_char_t   ch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_sync <= 2'b11;
        else        rx_sync <= {rx_sync[0], rx};
    end

    baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    rx_frame #(.OVS(OVS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_sync[1]),
        .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .ch_valid(ch_valid), .ch(ch)
    );

    blk_track #(.OVS(OVS), .CNT_W(CNT_W), .TO_W(TO_W)) u_blk (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ch_valid(ch_valid), .ch(ch),
        .len_sel(len_sel), .par_en(par_en), .two_stop(two_stop),
        .stat_en(stat_en), .term_en(term_en), .term_char(term_char),
        .force_end(force_end), .tout_en(tout_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_stat(wr_stat),
        .ev_term(ev_term), .ev_tout(ev_tout), .ev_perr(ev_perr),
        .ev_ferr(ev_ferr), .byte_cnt(byte_cnt), .blk_len(blk_len)
    );
endmodule

// File: tb/tb_async_blk_rx.sv
module tb_async_blk_rx;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [15:0] baud_div = '0;
    logic rx = 1'b1;
    logic [1:0] len_sel = 2'd3;
    logic par_en = 0, par_odd = 0, two_stop = 0, stat_en = 0;
    logic term_en = 0, force_end = 0, tout_en = 0;
    logic [7:0] term_char = 8'h0D;
    logic wr_valid, wr_stat, ev_term, ev_tout, ev_perr, ev_ferr;
    logic [7:0] wr_data, byte_cnt, blk_len;

    async_blk_rx dut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rx(rx),
        .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .stat_en(stat_en), .term_en(term_en),
        .term_char(term_char), .force_end(force_end), .tout_en(tout_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_stat(wr_stat),
        .ev_term(ev_term), .ev_tout(ev_tout), .ev_perr(ev_perr),
        .ev_ferr(ev_ferr), .byte_cnt(byte_cnt), .blk_len(blk_len)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0, errors = 0;
    logic [8:0] exp_q[$];
    int n_wr = 0, n_term = 0, n_tout = 0, n_perr = 0, n_ferr = 0;
    int e_term = 0, e_perr = 0, e_ferr = 0, m_cnt = 0, e_blk = 0;
    logic [7:0] last_blk = '0;

    task automatic chk(input string req, input int got, input int expv);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    // reference model compared each clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                n_wr++;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2: unexpected write got %0h expected none",
                             {wr_stat, wr_data});
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    if (e != {wr_stat, wr_data}) begin
                        errors++;
                        $display("FAIL R2/R6: write got %0h expected %0h",
                                 {wr_stat, wr_data}, e);
                    end
                end
            end
            if (ev_term) begin n_term++; last_blk = blk_len; end
            if (ev_tout) n_tout++;
            if (ev_perr) n_perr++;
            if (ev_ferr) n_ferr++;
        end
    end

    task automatic bitt(input logic v);
        rx = v;
        repeat (16) @(negedge clk);
    endtask

    task automatic idle(input int bits);
        repeat (bits) bitt(1'b1);
    endtask

    task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        int nb;
        logic [7:0] m;
        logic p, pe_x;
        nb = 5 + len_sel;
        m = 8'(( 1 << nb) - 1);
        p = ^(d & m) ^ par_odd ^ bad_par;
        pe_x = par_en & bad_par;
        exp_q.push_back({1'b0, d & m});
        if (stat_en) exp_q.push_back({1'b1, 6'b0, bad_stop, pe_x});
        if (pe_x) e_perr++;
        if (bad_stop) e_ferr++;
        m_cnt++;
        if (term_en && (d & m) == term_char) begin
            e_term++; e_blk = m_cnt; m_cnt = 0;
        end
        bitt(1'b0);
        for (int i = 0; i < nb; i++) bitt(d[i]);
        if (par_en) bitt(p);
        if (two_stop) bitt(1'b1);
        bitt(!bad_stop);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 wr_valid", int'(wr_valid), 0);
        chk("R1 events", int'({ev_term, ev_tout, ev_perr, ev_ferr}), 0);
        chk("R1 byte_cnt", int'(byte_cnt), 0);
        chk("R1 blk_len", int'(blk_len), 0);
        rst_n = 1'b1;
        idle(2);

        // R2 8N1 characters
        send(8'hA5, 0, 0); idle(2);
        send(8'h3C, 0, 0); idle(2);
        chk("R2 queue drained", exp_q.size(), 0);
        chk("R10 byte_cnt", int'(byte_cnt), m_cnt);

        // R2 five-bit characters
        len_sel = 2'd0;
        send(8'hF5, 0, 0); idle(2);
        chk("R2 5-bit drained", exp_q.size(), 0);
        len_sel = 2'd1;
        send(8'h2A, 0, 0); idle(2);
        chk("R2 6-bit drained", exp_q.size(), 0);
        len_sel = 2'd3;

        // R3 glitch rejection
        begin
            int w0;
            w0 = n_wr;
            rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
            idle(3);
            chk("R3 no write", n_wr, w0);
            chk("R3 byte_cnt", int'(byte_cnt), m_cnt);
        end

        // R4 parity even / odd
        par_en = 1;
        send(8'h5A, 0, 0); idle(2);
        chk("R4 even good", n_perr, e_perr);
        send(8'h5B, 1, 0); idle(2);
        chk("R4 even bad", n_perr, e_perr);
        par_odd = 1;
        send(8'h11, 0, 0); idle(2);
        chk("R4 odd good", n_perr, e_perr);
        send(8'h13, 1, 0); idle(2);
        chk("R4 odd bad", n_perr, 2);
        par_en = 0; par_odd = 0;

        // R5 framing error, second stop bit low
        two_stop = 1;
        send(8'h77, 0, 0); idle(2);
        chk("R5 good two stop", n_ferr, 0);
        send(8'h78, 0, 1); idle(2);
        chk("R5 bad second stop", n_ferr, e_ferr);
        two_stop = 0;

        // R6 status byte
        stat_en = 1; par_en = 1;
        send(8'h42, 1, 0); idle(2);
        send(8'h43, 0, 1); idle(2);
        chk("R6 status drained", exp_q.size(), 0);
        stat_en = 0; par_en = 0;
        chk("R10 byte_cnt pre-term", int'(byte_cnt), m_cnt);

        // R7 termination character
        term_en = 1;
        send(8'h61, 0, 0); idle(2);
        send(8'h0D, 0, 0); idle(2);
        chk("R7 ev_term", n_term, e_term);
        chk("R7 blk_len", int'(last_blk), e_blk);
        chk("R7 byte_cnt cleared", int'(byte_cnt), 0);

        // R8 force end
        send(8'h01, 0, 0); idle(1);
        send(8'h02, 0, 0); idle(1);
        send(8'h03, 0, 0); idle(1);
        force_end = 1; @(negedge clk); force_end = 0;
        e_term++; e_blk = m_cnt; m_cnt = 0;
        idle(1);
        chk("R8 ev_term", n_term, e_term);
        chk("R8 blk_len", int'(last_blk), 3);
        chk("R8 byte_cnt cleared", int'(byte_cnt), 0);
        term_en = 0;

        // R9 time-out, 8N1: CFL 10, limit 640 clocks
        tout_en = 1;
        send(8'h55, 0, 0);
        rx = 1'b1;
        repeat (610) @(negedge clk);
        chk("R9 not early", n_tout, 0);
        repeat (50) @(negedge clk);
        chk("R9 fired", n_tout, 1);
        repeat (1400) @(negedge clk);
        chk("R9 once per idle", n_tout, 1);
        tout_en = 0;
        send(8'h66, 0, 0);
        rx = 1'b1;
        repeat (1400) @(negedge clk);
        chk("R9 disabled", n_tout, 1);
        chk("R2 final drained", exp_q.size(), 0);
        chk("R10 final count", int'(byte_cnt), m_cnt);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule